// File: doc/BRIEF.md
# Multi-Format Narrow Element Multiplier

This block takes one operand byte for A and one for B. It decodes each byte in a number format chosen by a 3-bit code, and the codes for A and B are independent. The block then forms the exact product as a sign, a signed exponent and an unsigned integer significand, with the value sign × significand × 2^exponent. The supported formats are five narrow floating-point layouts (E4M3, E5M2, E3M2, E2M3, E2M1) and two 8-bit integer modes. The floating-point decoding handles subnormals. Only E5M2 has infinity and NaN encodings. Separate flags report a NaN result and an infinite result. Shared block scaling, alignment, rounding and accumulation are not part of this block. It feeds a downstream aligner and accumulator.

A packed mode treats each input byte as two E2M1 nibbles. In that mode the block computes two independent products per cycle on two lanes: lane 0 takes the low nibbles and lane 1 takes the high nibbles. The datapath is combinational. An output register stage, selected by a parameter and enabled by default, adds one cycle of latency.

Each lane classifies its product into one of three states. PROD_FINITE covers ordinary values. PROD_INF is entered when one operand is infinite and the other is a nonzero non-NaN value. PROD_NAN is entered when either operand is NaN, or when infinity meets zero. The class is decided again every cycle from the current operands, and each state sets exactly one output form.

Top module: `mxm_elem_mul`

## Requirements
- R1: Format codes are 0 = E4M3, 1 = E5M2, 2 = E3M2, 3 = E2M3, 4 = E2M1, 5 = INT8, 6 = symmetric INT8. Code 7 is reserved, and an operand in code 7 decodes as a positive zero with no flags.
- R2: A floating-point element with biased exponent field e ≠ 0 and mantissa field m (M bits) decodes to significand 2^M + m and exponent e − bias − M. The biases are 7 (E4M3), 15 (E5M2), 3 (E3M2), 1 (E2M3) and 1 (E2M1). The sign is the top bit of the format's width.
- R3: A floating-point element with exponent field zero is subnormal. It decodes to significand m, with no hidden one, and exponent 1 − bias − M.
- R4: For a finite product, out_sign is the XOR of the operand signs, out_exp is the sum of the operand exponents, and out_sig is the product of the operand significands.
- R5: INT8 is two's complement. It decodes to exponent 0 and significand |value|, so 0x80 gives 128.
- R6: Symmetric INT8 decodes like INT8, except that 0x80 decodes as −127.
- R7: In E5M2, exponent field 31 with mantissa 0 is infinity, and with a nonzero mantissa it is NaN. In every other format an all-ones exponent field is an ordinary finite value; for example, E4M3 0x7F is 480.
- R8: out_nan is set if either operand is NaN, or if infinity meets zero. Otherwise out_inf is set if either operand is infinite. When either flag is set, out_sig and out_exp are 0 and out_sign is still the XOR of the signs. The two flags are never set together.
- R9: Format E2M1 uses only bits [3:0] of its byte: bit 3 is the sign, bits [2:1] the exponent and bit 0 the mantissa. Bits [7:4] have no effect when packed mode is off.
- R10: Operands A and B are decoded with their own format codes in the same cycle.
- R11: With packed_en = 1, both lanes decode as E2M1 whatever fmt_a and fmt_b hold. Lane 0 takes bits [3:0] of each byte and lane 1 takes bits [7:4]. With packed_en = 0, all lane 1 outputs are 0.
- R12: out_valid lane 0 follows in_valid, and lane 1 follows in_valid AND packed_en. With OUT_REG = 1, every output appears one cycle after its inputs, and an active-low reset clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle are meaningful |
| packed_en | input | 1 | Two E2M1 elements per byte, two lanes active |
| fmt_a | input | 3 | Format code for operand A |
| fmt_b | input | 3 | Format code for operand B |
| elem_a | input | 8 | Operand A byte |
| elem_b | input | 8 | Operand B byte |
| out_valid | output | 2 | Per-lane result valid |
| out_sign | output | 2 | Per-lane product sign |
| out_exp | output | 14 | Per-lane signed product exponent, 7 bits per lane, lane 0 in [6:0] |
| out_sig | output | 32 | Per-lane product significand, 16 bits per lane, lane 0 in [15:0] |
| out_nan | output | 2 | Per-lane NaN result flag |
| out_inf | output | 2 | Per-lane infinite result flag |

## Verification
Special-value classification and the zero test of the other operand meet in a single product when an E5M2 infinity is paired with a zero in any format. The bench provokes this with infinity against 0x00 on both the A and the B side, and with NaN against infinity. It judges the results by requiring the NaN flag alone, a cleared significand and exponent, and the XOR sign. Packed mode puts both lanes in the same cycle: the bench drives bytes whose two nibbles differ, including a nibble in the high half that would change lane 0 if it leaked, and compares each lane against its own reference product on every clock.

// File: rtl/mxm_pkg.sv
package mxm_pkg;

    localparam int ELEM_W = 8;
    localparam int NIB_W  = ELEM_W / 2;
    localparam int FMT_W  = 3;
    localparam int SIG_W  = ELEM_W;
    localparam int EXP_W  = 6;
    localparam int PSIG_W = 2 * SIG_W;
    localparam int PEXP_W = EXP_W + 1;
    localparam int LANES  = 2;

    typedef enum logic [FMT_W-1:0] {
        FMT_E4M3  = 3'd0,
        FMT_E5M2  = 3'd1,
        FMT_E3M2  = 3'd2,
        FMT_E2M3  = 3'd3,
        FMT_E2M1  = 3'd4,
        FMT_INT8  = 3'd5,
        FMT_SINT8 = 3'd6,
        FMT_RSVD  = 3'd7
    } fmt_e;

    typedef struct packed {
        logic                    sign;
        logic signed [EXP_W-1:0] exp;
        logic [SIG_W-1:0]        sig;
        logic                    is_nan;
        logic                    is_inf;
    } elem_t;

    typedef struct packed {
        logic                     sign;
        logic signed [PEXP_W-1:0] exp;
        logic [PSIG_W-1:0]        sig;
        logic                     nan;
        logic                     inf;
    } prod_t;

endpackage

// File: rtl/mxm_decode.sv
module mxm_decode
    import mxm_pkg::*;
(
    input  fmt_e              fmt,
    input  logic [ELEM_W-1:0] code,
    output elem_t             dec
);

    function automatic elem_t float_dec(input logic [ELEM_W-1:0] c,
                                        input int eb, input int mb,
                                        input int bias, input logic has_special);
        elem_t             r;
        logic [ELEM_W-1:0] emax;
        logic [ELEM_W-1:0] ef;
        logic [ELEM_W-1:0] mf;
        int                e_i;
        r    = '0;
        e_i  = 0;
        emax = ELEM_W'((1 << eb) - 1);
        ef   = (c >> mb) & emax;
        mf   = c & ELEM_W'((1 << mb) - 1);
        r.sign = c[eb + mb];
        if (has_special && ef == emax) begin
            r.is_inf = (mf == '0);
            r.is_nan = (mf != '0);
        end else if (ef == '0) begin
            r.sig = mf;
            e_i   = 1 - bias - mb;
            r.exp = EXP_W'(e_i);
        end else begin
            r.sig = mf | ELEM_W'(1 << mb);
            e_i   = int'(ef) - bias - mb;
            r.exp = EXP_W'(e_i);
        end
        return r;
    endfunction

    function automatic elem_t int_dec(input logic [ELEM_W-1:0] c, input logic sym);
        elem_t r;
        r      = '0;
        r.sign = c[ELEM_W-1];
        r.sig  = c[ELEM_W-1] ? ELEM_W'(-c) : c;
        if (sym && c == {1'b1, {(ELEM_W-1){1'b0}}})
            r.sig = {1'b0, {(ELEM_W-1){1'b1}}};
        return r;
    endfunction

    always_comb begin
        unique case (fmt)
            FMT_E4M3:  dec = float_dec(code, 4, 3, 7,  1'b0);
            FMT_E5M2:  dec = float_dec(code, 5, 2, 15, 1'b1);
            FMT_E3M2:  dec = float_dec(code, 3, 2, 3,  1'b0);
            FMT_E2M3:  dec = float_dec(code, 2, 3, 1,  1'b0);
            FMT_E2M1:  dec = float_dec(code, 2, 1, 1,  1'b0);
            FMT_INT8:  dec = int_dec(code, 1'b0);
            FMT_SINT8: dec = int_dec(code, 1'b1);
            FMT_RSVD:  dec = '0;
        endcase
    end

endmodule

// File: rtl/mxm_lane.sv
module mxm_lane
    import mxm_pkg::*;
(
    input  fmt_e              fmt_a,
    input  fmt_e              fmt_b,
    input  logic [ELEM_W-1:0] elem_a,
    input  logic [ELEM_W-1:0] elem_b,
    output prod_t             prod
);

    typedef enum logic [1:0] {
        PROD_FINITE = 2'd0,
        PROD_INF    = 2'd1,
        PROD_NAN    = 2'd2
    } cls_e;

    elem_t dec_a;
    elem_t dec_b;
    cls_e  cls;
    logic  a_zero;
    logic  b_zero;

    mxm_decode u_dec_a (.fmt(fmt_a), .code(elem_a), .dec(dec_a));
    mxm_decode u_dec_b (.fmt(fmt_b), .code(elem_b), .dec(dec_b));

    assign a_zero = !dec_a.is_nan && !dec_a.is_inf && (dec_a.sig == '0);
    assign b_zero = !dec_b.is_nan && !dec_b.is_inf && (dec_b.sig == '0);

    // Product class: NaN dominates, then infinity, else finite.
    always_comb begin
        if (dec_a.is_nan || dec_b.is_nan)
            cls = PROD_NAN;
        else if ((dec_a.is_inf && b_zero) || (dec_b.is_inf && a_zero))
            cls = PROD_NAN;
        else if (dec_a.is_inf || dec_b.is_inf)
            cls = PROD_INF;
        else
            cls = PROD_FINITE;
    end

    always_comb begin
        prod      = '0;
        prod.sign = dec_a.sign ^ dec_b.sign;
        unique case (cls)
            PROD_FINITE: begin
                prod.sig = PSIG_W'(dec_a.sig) * PSIG_W'(dec_b.sig);
                prod.exp = {dec_a.exp[EXP_W-1], dec_a.exp} + {dec_b.exp[EXP_W-1], dec_b.exp};
            end
            PROD_INF: prod.inf = 1'b1;
            PROD_NAN: prod.nan = 1'b1;
            default:  prod.nan = 1'b1;
        endcase
    end

endmodule

// File: rtl/mxm_elem_mul.sv
module mxm_elem_mul
    import mxm_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     packed_en,
    input  logic [FMT_W-1:0]         fmt_a,
    input  logic [FMT_W-1:0]         fmt_b,
    input  logic [ELEM_W-1:0]        elem_a,
    input  logic [ELEM_W-1:0]        elem_b,
    output logic [LANES-1:0]         out_valid,
    output logic [LANES-1:0]         out_sign,
    output logic [LANES*PEXP_W-1:0]  out_exp,
    output logic [LANES*PSIG_W-1:0]  out_sig,
    output logic [LANES-1:0]         out_nan,
    output logic [LANES-1:0]         out_inf
);

    prod_t [LANES-1:0] lane_p;
    prod_t [LANES-1:0] lane_q;
    logic  [LANES-1:0] lane_v;
    logic  [LANES-1:0] lane_vq;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        fmt_e              fa;
        fmt_e              fb;
        logic [ELEM_W-1:0] ca;
        logic [ELEM_W-1:0] cb;
        prod_t             raw;

        if (l == 0) begin : g_base
            assign fa = packed_en ? FMT_E2M1 : fmt_e'(fmt_a);
            assign fb = packed_en ? FMT_E2M1 : fmt_e'(fmt_b);
            assign ca = elem_a;
            assign cb = elem_b;
        end else begin : g_extra
            assign fa = FMT_E2M1;
            assign fb = FMT_E2M1;
            assign ca = ELEM_W'(elem_a >> (l * NIB_W));
            assign cb = ELEM_W'(elem_b >> (l * NIB_W));
        end

        mxm_lane u_lane (
            .fmt_a  (fa),
            .fmt_b  (fb),
            .elem_a (ca),
            .elem_b (cb),
            .prod   (raw)
        );

        assign lane_p[l] = (l == 0 || packed_en) ? raw : '0;
        assign lane_v[l] = in_valid && (l == 0 || packed_en);

        assign out_valid[l]                   = lane_vq[l];
        assign out_sign[l]                    = lane_q[l].sign;
        assign out_exp[l*PEXP_W +: PEXP_W]    = lane_q[l].exp;
        assign out_sig[l*PSIG_W +: PSIG_W]    = lane_q[l].sig;
        assign out_nan[l]                     = lane_q[l].nan;
        assign out_inf[l]                     = lane_q[l].inf;

        assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !(out_nan[l] && out_inf[l]));

        assert_special_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (out_nan[l] || out_inf[l]) |->
                (out_sig[l*PSIG_W +: PSIG_W] == '0 && out_exp[l*PEXP_W +: PEXP_W] == '0));
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q  <= '0;
                lane_vq <= '0;
            end else begin
                lane_q  <= lane_p;
                lane_vq <= lane_v;
            end
        end

        assert_valid_rise_R12: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid[0]);

        assert_valid_fall_R12: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid[0]);

        assert_lane1_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !packed_en |=> (!out_valid[1] && !out_nan[1] && !out_inf[1] &&
                            out_sig[PSIG_W +: PSIG_W] == '0));

        assert_int_exp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (!packed_en && fmt_a inside {FMT_INT8, FMT_SINT8} && fmt_b inside {FMT_INT8, FMT_SINT8})
                |=> (out_exp[PEXP_W-1:0] == '0));
    end else begin : g_comb
        assign lane_q  = lane_p;
        assign lane_vq = lane_v;
    end

endmodule

// File: tb/test_mxm_elem_mul.sv
module test_mxm_elem_mul;

    typedef struct {
        bit v;
        bit s;
        int e;
        int sig;
        bit nan;
        bit inf;
    } lane_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        packed_en = 1'b0;
    logic [2:0]  fmt_a = 3'd0;
    logic [2:0]  fmt_b = 3'd0;
    logic [7:0]  elem_a = 8'd0;
    logic [7:0]  elem_b = 8'd0;
    logic [1:0]  out_valid;
    logic [1:0]  out_sign;
    logic [13:0] out_exp;
    logic [31:0] out_sig;
    logic [1:0]  out_nan;
    logic [1:0]  out_inf;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    have_pend = 0;
    bit    done = 0;
    lane_t pend [2];
    string pend_tag;

    always #5 clk = ~clk;

    mxm_elem_mul i_mxm_elem_mul (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .packed_en(packed_en),
        .fmt_a(fmt_a), .fmt_b(fmt_b), .elem_a(elem_a), .elem_b(elem_b),
        .out_valid(out_valid), .out_sign(out_sign), .out_exp(out_exp),
        .out_sig(out_sig), .out_nan(out_nan), .out_inf(out_inf)
    );

    function automatic lane_t zero_lane();
        lane_t r;
        r.v = 0; r.s = 0; r.e = 0; r.sig = 0; r.nan = 0; r.inf = 0;
        return r;
    endfunction

    function automatic lane_t ref_dec(input logic [2:0] f, input logic [7:0] x);
        lane_t r;
        int eb, mb, bias, ef, mf, v;
        r = zero_lane();
        eb = 0; mb = 0; bias = 0;
        case (f)
            3'd0: begin eb = 4; mb = 3; bias = 7;  end
            3'd1: begin eb = 5; mb = 2; bias = 15; end
            3'd2: begin eb = 3; mb = 2; bias = 3;  end
            3'd3: begin eb = 2; mb = 3; bias = 1;  end
            3'd4: begin eb = 2; mb = 1; bias = 1;  end
            3'd5, 3'd6: begin
                v = $signed(x);
                if (f == 3'd6 && x == 8'h80) v = -127;
                r.s = (v < 0);
                r.sig = (v < 0) ? -v : v;
                return r;
            end
            default: return r;
        endcase
        ef = (int'(x) >> mb) % (1 << eb);
        mf = int'(x) % (1 << mb);
        r.s = ((int'(x) >> (eb + mb)) % 2) == 1;
        if (f == 3'd1 && ef == 31) begin
            if (mf == 0) r.inf = 1; else r.nan = 1;
            return r;
        end
        if (ef == 0) begin
            r.sig = mf; r.e = 1 - bias - mb;
        end else begin
            r.sig = mf + (1 << mb); r.e = ef - bias - mb;
        end
        return r;
    endfunction

    function automatic lane_t ref_mul(input lane_t a, input lane_t b);
        lane_t r;
        bit az, bz;
        r = zero_lane();
        r.s = a.s ^ b.s;
        az = !a.nan && !a.inf && a.sig == 0;
        bz = !b.nan && !b.inf && b.sig == 0;
        if (a.nan || b.nan || (a.inf && bz) || (b.inf && az)) r.nan = 1;
        else if (a.inf || b.inf) r.inf = 1;
        else begin
            r.sig = a.sig * b.sig;
            r.e = a.e + b.e;
        end
        return r;
    endfunction

    task automatic check_lanes(input lane_t exp_l [2], input string tag);
        for (int l = 0; l < 2; l++) begin
            lane_t g;
            g.v = out_valid[l];
            g.s = out_sign[l];
            g.e = $signed(out_exp[l*7 +: 7]);
            g.sig = int'(out_sig[l*16 +: 16]);
            g.nan = out_nan[l];
            g.inf = out_inf[l];
            n_checks++;
            if (g.v != exp_l[l].v || g.s != exp_l[l].s || g.e != exp_l[l].e ||
                g.sig != exp_l[l].sig || g.nan != exp_l[l].nan || g.inf != exp_l[l].inf) begin
                n_fail++;
                $display("FAIL %s lane%0d: got v=%0d s=%0d e=%0d sig=%0d nan=%0d inf=%0d expected v=%0d s=%0d e=%0d sig=%0d nan=%0d inf=%0d",
                    tag, l, g.v, g.s, g.e, g.sig, g.nan, g.inf,
                    exp_l[l].v, exp_l[l].s, exp_l[l].e, exp_l[l].sig, exp_l[l].nan, exp_l[l].inf);
            end
        end
    endtask

    task automatic check_zero(input string tag);
        lane_t z [2];
        z[0] = zero_lane();
        z[1] = zero_lane();
        check_lanes(z, tag);
    endtask

    task automatic apply(input bit v, input bit pk, input logic [2:0] fa, input logic [2:0] fb,
                         input logic [7:0] a, input logic [7:0] b, input string tag);
        @(negedge clk);
        if (have_pend) check_lanes(pend, pend_tag);
        in_valid = v; packed_en = pk; fmt_a = fa; fmt_b = fb; elem_a = a; elem_b = b;
        if (pk) begin
            pend[0] = ref_mul(ref_dec(3'd4, a & 8'h0F), ref_dec(3'd4, b & 8'h0F));
            pend[1] = ref_mul(ref_dec(3'd4, a >> 4), ref_dec(3'd4, b >> 4));
            pend[1].v = v;
        end else begin
            pend[0] = ref_mul(ref_dec(fa, a), ref_dec(fb, b));
            pend[1] = zero_lane();
        end
        pend[0].v = v;
        pend_tag = tag;
        have_pend = 1;
    endtask

    task automatic flush();
        @(negedge clk);
        if (have_pend) check_lanes(pend, pend_tag);
        have_pend = 0;
        in_valid = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: got no completion, expected finish in time");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_zero("R12 reset");
        rst_n = 1'b1;

        apply(1, 0, 3'd0, 3'd0, 8'h38, 8'h38, "R2 e4m3 one*one");
        apply(1, 0, 3'd1, 3'd2, 8'h3C, 8'h0C, "R10 e5m2*e3m2");
        apply(1, 0, 3'd3, 3'd2, 8'h2F, 8'hB3, "R10 e2m3*e3m2");
        apply(1, 0, 3'd0, 3'd3, 8'h01, 8'h01, "R3 subnormals");
        apply(1, 0, 3'd1, 3'd4, 8'h83, 8'h09, "R3 e5m2 sub*e2m1");
        apply(1, 0, 3'd0, 3'd0, 8'h7F, 8'h38, "R7 e4m3 max finite");
        apply(1, 0, 3'd2, 3'd3, 8'h7F, 8'hBF, "R7 all-ones finite");
        apply(1, 0, 3'd1, 3'd0, 8'h7C, 8'h38, "R7 inf*one");
        apply(1, 0, 3'd1, 3'd0, 8'hFC, 8'h38, "R8 neg inf sign");
        apply(1, 0, 3'd1, 3'd0, 8'h7C, 8'h00, "R8 inf*zero");
        apply(1, 0, 3'd5, 3'd1, 8'h00, 8'hFC, "R8 zero*inf");
        apply(1, 0, 3'd1, 3'd1, 8'h7D, 8'h7C, "R8 nan*inf");
        apply(1, 0, 3'd1, 3'd1, 8'hFC, 8'h7C, "R8 inf*inf");
        apply(1, 0, 3'd5, 3'd5, 8'h80, 8'h02, "R5 int8 min");
        apply(1, 0, 3'd5, 3'd5, 8'hFF, 8'hFF, "R5 int8 neg*neg");
        apply(1, 0, 3'd6, 3'd6, 8'h80, 8'h01, "R6 sym 0x80");
        apply(1, 0, 3'd6, 3'd0, 8'h81, 8'h38, "R6 sym mixed");
        apply(1, 0, 3'd4, 3'd4, 8'hF3, 8'hA3, "R9 high nibble ignored");
        apply(1, 0, 3'd4, 3'd4, 8'h03, 8'h03, "R9 clean nibbles");
        apply(1, 0, 3'd7, 3'd0, 8'hC5, 8'h38, "R1 reserved code");
        apply(0, 0, 3'd0, 3'd0, 8'h40, 8'h40, "R12 invalid");
        apply(1, 1, 3'd5, 3'd1, 8'h3A, 8'h25, "R11 packed two lanes");
        apply(1, 1, 3'd0, 3'd0, 8'hF7, 8'h8F, "R11 packed signs");
        apply(0, 1, 3'd0, 3'd0, 8'h11, 8'h22, "R11 packed not valid");
        apply(1, 0, 3'd0, 3'd0, 8'h3A, 8'h25, "R11 unpacked lane1 idle");
        flush();

        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_zero("R12 mid reset");
        rst_n = 1'b1;

        for (int i = 0; i < 3000; i++) begin
            logic [7:0] ra, rb;
            logic [2:0] fa, fb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            fa = 3'($urandom % 7);
            fb = 3'($urandom % 7);
            apply(1'($urandom), ($urandom % 4) == 0, fa, fb, ra, rb, "R4 random");
        end
        flush();

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule